// File: doc/BRIEF.md
# Wide Memory Access Unit

This unit executes the three memory instructions that exist only on the 64-bit integer machine: an unsigned 32-bit word read, a 64-bit doubleword read and a 64-bit doubleword write. It takes a 32-bit instruction word with two 64-bit source operands. For each legal instruction it issues one memory request, and for reads it returns a register write-back. The unit handles one instruction at a time and shows it can take a new one with `instr_rdy`.

A small state machine controls each instruction. **ST_IDLE** waits for `instr_valid`. A legal instruction takes the transition *accept* to **ST_ISSUE**. There the request is driven for one cycle. A write then takes *write_done* back to ST_IDLE. A read takes *await* to **ST_WAIT**, which holds until `rsp_valid` and then takes *respond* to **ST_WRITE**. ST_WRITE presents the write-back for one cycle and takes *retire* to ST_IDLE. An instruction that is not recognised in ST_IDLE takes the *reject* self-loop: the state stays ST_IDLE and `illegal` pulses.

Top module: `wide_mem_unit`

## Requirements
- R1: With opcode bits [6:0]=0000011 and bits [14:12]=110, the unit issues a read (`mem_we`=0). The address is `src_a` plus the sign-extended instruction bits [31:20], added at full 64-bit width.
- R2: With opcode 0000011 and bits [14:12]=011, the unit issues a read with `mem_be`=8'hFF. The write-back value is the full 64-bit `rsp_data`.
- R3: With opcode 0100011 and bits [14:12]=011, the unit issues a write with `mem_we`=1, `mem_be`=8'hFF and `mem_wdata`=`src_b`. The address is `src_a` plus the sign extension of {instr[31:25], instr[11:7]}. A write produces no write-back.
- R4: For the word read, `mem_be` is 8'h0F when address bit 2 is 0 and 8'hF0 when it is 1. The write-back value is the matching 32-bit half of `rsp_data`, zero-extended to 64 bits.
- R5: A read whose destination field (bits [11:7]) is 0 never asserts `wb_en`.
- R6: Any other opcode and bits [14:12] combination accepted in ST_IDLE raises `illegal` for exactly the following cycle and issues no request.
- R7: `mem_req` is high for exactly one cycle per legal instruction. That cycle is the one after the instruction is accepted.
- R8: For a read, `wb_en` (destination non-zero) together with `wb_idx` and `wb_data` is presented for exactly one cycle. That cycle is the one after `rsp_valid` is seen in ST_WAIT.
- R9: `instr_valid` while `instr_rdy` is low is ignored. It causes no request, no illegal flag and no change to the instruction in progress.
- R10: After reset the unit is in ST_IDLE: `instr_rdy`=1 and `mem_req`, `illegal` and `wb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | Base register value |
| src_b | input | 64 | Store data register value |
| instr_rdy | output | 1 | Unit idle, instruction will be taken |
| illegal | output | 1 | Unrecognised instruction pulse |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Effective address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 64 | Read data |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Write-back value |

## Verification
The bench builds the unit with its default parameters: 64-bit data, 32-bit instruction and 5-bit register index. With these values address bit 2 selects the word lane, and a 12-bit negative offset wraps correctly across the whole 64-bit address. Both halves of a word read with the upper bit set can then be checked for zero extension rather than sign extension. Response delays from zero to several cycles exercise the hold in ST_WAIT, and poking instructions into that wait checks that they are ignored while busy.

// File: rtl/wmu_pkg.sv
package wmu_pkg;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [2:0] F3_WORD_U = 3'b110;
    localparam logic [2:0] F3_DWORD  = 3'b011;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_WORD_RD,
        ACC_DWORD_RD,
        ACC_DWORD_WR
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE
    } state_e;
endpackage

// File: rtl/wmu_decode.sv
module wmu_decode
    import wmu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5
) (
    input  logic [31:0]       instr,
    output acc_e              acc,
    output logic              legal,
    output logic [DATA_W-1:0] imm,
    output logic [IDX_W-1:0]  rd
);
    localparam int IMM_W = 12;
    localparam int EXT_W = DATA_W - IMM_W;

    logic [6:0]       opcode;
    logic [2:0]       f3;
    logic [IMM_W-1:0] imm_rd_form;
    logic [IMM_W-1:0] imm_wr_form;

    assign opcode      = instr[6:0];
    assign f3          = instr[14:12];
    assign rd          = instr[7 +: IDX_W];
    assign imm_rd_form = instr[31:20];
    assign imm_wr_form = {instr[31:25], instr[11:7]};

    always_comb begin
        acc = ACC_NONE;
        imm = {{EXT_W{imm_rd_form[IMM_W-1]}}, imm_rd_form};
        if (opcode == OPC_LOAD && f3 == F3_WORD_U) begin
            acc = ACC_WORD_RD;
        end else if (opcode == OPC_LOAD && f3 == F3_DWORD) begin
            acc = ACC_DWORD_RD;
        end else if (opcode == OPC_STORE && f3 == F3_DWORD) begin
            acc = ACC_DWORD_WR;
            imm = {{EXT_W{imm_wr_form[IMM_W-1]}}, imm_wr_form};
        end
    end

    assign legal = (acc != ACC_NONE);
endmodule

// File: rtl/wmu_agen.sv
module wmu_agen
    import wmu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0]   base,
    input  logic [DATA_W-1:0]   imm,
    input  acc_e                acc,
    output logic [DATA_W-1:0]   addr,
    output logic [DATA_W/8-1:0] be
);
    localparam int BE_W    = DATA_W / 8;
    localparam int WBE_W   = WORD_W / 8;
    localparam int SEL_BIT = $clog2(WBE_W);

    assign addr = base + imm;

    always_comb begin
        be = '1;
        if (acc == ACC_WORD_RD) begin
            be = {{(BE_W - WBE_W){1'b0}}, {WBE_W{1'b1}}};
            if (addr[SEL_BIT]) begin
                be = be << WBE_W;
            end
        end
    end
endmodule

// File: rtl/wmu_ldfmt.sv
module wmu_ldfmt #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              word,
    input  logic              upper,
    output logic [DATA_W-1:0] res
);
    localparam int PAD_W = DATA_W - WORD_W;

    logic [WORD_W-1:0] half;

    assign half = upper ? raw[DATA_W-1 -: WORD_W] : raw[WORD_W-1:0];
    assign res  = word ? {{PAD_W{1'b0}}, half} : raw;
endmodule

// File: rtl/wide_mem_unit.sv
module wide_mem_unit
    import wmu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int INSTR_W = 32,
    parameter int IDX_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    output logic                instr_rdy,
    output logic                illegal,
    output logic                mem_req,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                rsp_valid,
    input  logic [DATA_W-1:0]   rsp_data,
    output logic                wb_en,
    output logic [IDX_W-1:0]    wb_idx,
    output logic [DATA_W-1:0]   wb_data
);
    localparam int WORD_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int SEL_BIT = $clog2(WORD_W / 8);

    state_e             state_q, state_d;
    acc_e               dec_acc;
    logic               dec_legal;
    logic [DATA_W-1:0]  dec_imm;
    logic [IDX_W-1:0]   dec_rd;
    logic [DATA_W-1:0]  ag_addr;
    logic [BE_W-1:0]    ag_be;
    logic [DATA_W-1:0]  fmt_res;
    logic               take;

    logic [DATA_W-1:0]  addr_q;
    logic [BE_W-1:0]    be_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               we_q;
    logic               word_q;
    logic [IDX_W-1:0]   rd_q;
    logic [DATA_W-1:0]  wbval_q;
    logic               ill_q;
    logic [9:0]         unused_fields;

    assign unused_fields = instr[24:15];

    wmu_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
        .instr (instr[31:0]),
        .acc   (dec_acc),
        .legal (dec_legal),
        .imm   (dec_imm),
        .rd    (dec_rd)
    );

    wmu_agen #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_agen (
        .base (src_a),
        .imm  (dec_imm),
        .acc  (dec_acc),
        .addr (ag_addr),
        .be   (ag_be)
    );

    wmu_ldfmt #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_fmt (
        .raw   (rsp_data),
        .word  (word_q),
        .upper (addr_q[SEL_BIT]),
        .res   (fmt_res)
    );

    assign take = (state_q == ST_IDLE) && instr_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take && dec_legal) state_d = ST_ISSUE;
            ST_ISSUE: state_d = we_q ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured instruction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            word_q  <= 1'b0;
            rd_q    <= '0;
            wbval_q <= '0;
            ill_q   <= 1'b0;
        end else begin
            ill_q <= take && !dec_legal;
            if (take && dec_legal) begin
                addr_q  <= ag_addr;
                be_q    <= ag_be;
                wdata_q <= src_b;
                we_q    <= (dec_acc == ACC_DWORD_WR);
                word_q  <= (dec_acc == ACC_WORD_RD);
                rd_q    <= dec_rd;
            end
            if (state_q == ST_WAIT && rsp_valid) begin
                wbval_q <= fmt_res;
            end
        end
    end

    // outputs
    always_comb begin
        instr_rdy = (state_q == ST_IDLE);
        illegal   = ill_q;
        mem_req   = (state_q == ST_ISSUE);
        mem_we    = we_q;
        mem_addr  = addr_q;
        mem_be    = be_q;
        mem_wdata = wdata_q;
        wb_en     = (state_q == ST_WRITE) && (rd_q != '0);
        wb_idx    = rd_q;
        wb_data   = wbval_q;
    end
endmodule

// File: rtl/wmu_checker.sv
module wmu_checker #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                instr_valid,
    input logic                instr_rdy,
    input logic                illegal,
    input logic                mem_req,
    input logic                mem_we,
    input logic [DATA_W/8-1:0] mem_be,
    input logic                rsp_valid,
    input logic                wb_en,
    input logic [IDX_W-1:0]    wb_idx
);
    p_write_full_be_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be == '1));

    p_read_be_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_be == 8'hFF || mem_be == 8'h0F || mem_be == 8'hF0));

    p_no_zero_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != '0));

    p_illegal_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && $past(instr_valid && instr_rdy)));

    p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_req_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(instr_valid && instr_rdy));

    p_wb_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ($past(rsp_valid) && !mem_req));

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || wb_en) |-> !instr_rdy);
endmodule

bind wide_mem_unit wmu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/wide_mem_unit_test.sv
`timescale 1ns/1ps
module wide_mem_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        instr_rdy, illegal, mem_req, mem_we, wb_en;
    logic [63:0] mem_addr, mem_wdata, wb_data;
    logic [7:0]  mem_be;
    logic [4:0]  wb_idx;

    int errors = 0;
    int checks = 0;

    // expectations for the current cycle
    logic        e_rdy = 1'b1, e_ill = 1'b0, e_req = 1'b0, e_we = 1'b0, e_wb = 1'b0;
    logic [63:0] e_addr = '0, e_wdata = '0, e_wbdata = '0;
    logic [7:0]  e_be = '0;
    logic [4:0]  e_idx = '0;
    string       tag = "R10";
    bit          live = 1'b0;

    always #10 clk = ~clk;

    wide_mem_unit uut (.*);

    task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            chk(instr_rdy == e_rdy, {tag, " rdy"}, 64'(instr_rdy), 64'(e_rdy));
            chk(illegal == e_ill, {tag, " illegal"}, 64'(illegal), 64'(e_ill));
            chk(mem_req == e_req, {tag, " req"}, 64'(mem_req), 64'(e_req));
            chk(wb_en == e_wb, {tag, " wb_en"}, 64'(wb_en), 64'(e_wb));
            if (e_req) begin
                chk(mem_we == e_we, {tag, " we"}, 64'(mem_we), 64'(e_we));
                chk(mem_addr == e_addr, {tag, " addr"}, mem_addr, e_addr);
                chk(mem_be == e_be, {tag, " be"}, 64'(mem_be), 64'(e_be));
                if (e_we) chk(mem_wdata == e_wdata, {tag, " wdata"}, mem_wdata, e_wdata);
            end
            if (e_wb) begin
                chk(wb_idx == e_idx, {tag, " idx"}, 64'(wb_idx), 64'(e_idx));
                chk(wb_data == e_wbdata, {tag, " wbdata"}, wb_data, e_wbdata);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [63:0] sx12(input logic [11:0] v);
        return 64'($signed(v));
    endfunction

    function automatic logic [31:0] rd_form(input logic [11:0] imm, input logic [2:0] f3, input logic [4:0] rd);
        return {imm, 5'd3, f3, rd, 7'b0000011};
    endfunction

    function automatic logic [31:0] wr_form(input logic [11:0] imm, input logic [2:0] f3);
        return {imm[11:5], 5'd4, 5'd3, f3, imm[4:0], 7'b0100011};
    endfunction

    task automatic do_read(input bit word, input logic [11:0] imm, input logic [4:0] rd,
                           input logic [63:0] a, input int dly, input logic [63:0] mem,
                           input bit poke, input string t);
        logic [63:0] ea;
        ea = a + sx12(imm);
        tag = t;
        instr_valid = 1'b1;
        instr = rd_form(imm, word ? 3'b110 : 3'b011, rd);
        src_a = a;
        step();
        instr_valid = 1'b0;
        e_rdy = 1'b0; e_req = 1'b1; e_we = 1'b0; e_addr = ea;
        e_be = word ? (ea[2] ? 8'hF0 : 8'h0F) : 8'hFF;
        step();
        e_req = 1'b0;
        for (int i = 0; i < dly; i++) begin
            if (poke) begin
                instr_valid = 1'b1;
                instr = (i % 2 == 0) ? wr_form(12'h010, 3'b011) : 32'h0000_0013;
            end
            step();
        end
        instr_valid = 1'b0;
        rsp_valid = 1'b1;
        rsp_data = mem;
        step();
        rsp_valid = 1'b0;
        rsp_data = ~mem;
        e_wb = (rd != 5'd0);
        e_idx = rd;
        e_wbdata = word ? {32'd0, (ea[2] ? mem[63:32] : mem[31:0])} : mem;
        step();
        e_wb = 1'b0;
        e_rdy = 1'b1;
    endtask

    task automatic do_write(input logic [11:0] imm, input logic [63:0] a, input logic [63:0] b, input string t);
        tag = t;
        instr_valid = 1'b1;
        instr = wr_form(imm, 3'b011);
        src_a = a;
        src_b = b;
        step();
        instr_valid = 1'b0;
        e_rdy = 1'b0; e_req = 1'b1; e_we = 1'b1;
        e_addr = a + sx12(imm); e_be = 8'hFF; e_wdata = b;
        step();
        e_req = 1'b0; e_rdy = 1'b1;
        step();
    endtask

    task automatic do_bad(input logic [31:0] w, input string t);
        tag = t;
        instr_valid = 1'b1;
        instr = w;
        step();
        instr_valid = 1'b0;
        e_ill = 1'b1;
        step();
        e_ill = 1'b0;
        step();
    endtask

    initial begin
        repeat (3) step();
        live = 1'b1;
        tag = "R10";
        step();
        rst_n = 1'b1;
        step();
        step();
        // R1 / R4: word read, lower lane
        do_read(1'b1, 12'h010, 5'd5, 64'h0000_0000_0000_1000, 1, 64'hDEAD_BEEF_8765_4321, 1'b0, "R1");
        // R4: upper lane, negative offset, sign bit of the half set
        do_read(1'b1, 12'hFFC, 5'd7, 64'h0000_0000_0000_2000, 0, 64'hF234_5678_0000_0001, 1'b0, "R4");
        // R2 / R8: doubleword read with a slow response
        do_read(1'b0, 12'h7F8, 5'd31, 64'hFFFF_FFFF_FFFF_F000, 3, 64'h8000_0000_0000_00FF, 1'b0, "R8");
        do_read(1'b0, 12'h800, 5'd1, 64'h1234_5678_9ABC_DEF0, 0, 64'h0123_4567_89AB_CDEF, 1'b0, "R2");
        // R5: destination zero
        do_read(1'b0, 12'h008, 5'd0, 64'h0000_0000_0000_0100, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R5");
        do_read(1'b1, 12'h004, 5'd0, 64'h0000_0000_0000_0100, 0, 64'hAAAA_5555_AAAA_5555, 1'b0, "R5");
        // R3: write with split offset, positive and negative
        do_write(12'h7E5, 64'h0000_0000_0001_0000, 64'hCAFE_F00D_1234_5678, "R3");
        do_write(12'h81F, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001, "R3");
        do_write(12'hFFF, 64'h0, 64'hFFFF_0000_FFFF_0000, "R3");
        // R6: unrecognised combinations
        do_bad(rd_form(12'h0, 3'b010, 5'd3), "R6");
        do_bad(wr_form(12'h0, 3'b010), "R6");
        do_bad(32'h0010_0093, "R6");
        do_bad({12'h0, 5'd3, 3'b011, 5'd3, 7'b0000111}, "R6");
        // R9: pokes while waiting are ignored
        do_read(1'b1, 12'h024, 5'd9, 64'h0000_0000_0000_3000, 4, 64'h1111_2222_3333_4444, 1'b1, "R9");
        // R7: back-to-back work after the pokes
        do_write(12'h000, 64'h0000_0000_0000_4000, 64'h5A5A_5A5A_5A5A_5A5A, "R7");
        repeat (2) step();
        live = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule